// File: doc/BRIEF.md
# Cartridge Program and Work-RAM Bank Mapper

This block sits between an 8-bit console's CPU bus and the memories on a cartridge. CPU stores into the upper half of the address space are captured in two 4-bit write-only registers: the lower quarter ($8000-$BFFF) loads the "page" register and the upper quarter ($C000-$FFFF) loads the "bank" register. From these registers and a few static board straps the block forms the upper program-flash address lines, the flash chip enable and output enable, the work-RAM page lines and chip enable, and the nametable select line that drives the console's internal video RAM.

The program window is split into two modes by a strap. In the 16 KB mode the lower 16 KB window is switchable and the upper 16 KB window is pinned to the last bank of the current 256 KB half. In the 32 KB mode one switchable 32 KB bank covers the whole window. A second strap tells the block how large the flash part is, so that address lines beyond the fitted flash are held low. A third strap selects the nametable arrangement. The 32 KB of work RAM is seen through an 8 KB window at $6000-$7FFF, with the page picked from the page register.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset both registers hold zero, so a read at $8000 in 16 KB mode with a 512 KB flash gives program bank 0 and the work-RAM page lines read 0.
- R2: A CPU write (cpu_rw_i=0 with m2_i=1) to $8000-$BFFF loads data bits 3:0 into the page register at the next clk_i edge: bit 3 is the 256 KB half select, bits 2:1 the work-RAM page, bit 0 the single-screen nametable.
- R3: A CPU write to $C000-$FFFF loads data bits 3:0 into the bank register and leaves the page register unchanged.
- R4: In 16 KB mode (cfg_prg32_i=0) a read in $8000-$BFFF gives prg_addr_o = {half, bank[3:0]}, where prg_addr_o bit 0 is flash address bit 14.
- R5: In 16 KB mode a read in $C000-$FFFF gives prg_addr_o = {half, 4'b1111} regardless of the bank register.
- R6: In 32 KB mode (cfg_prg32_i=1) prg_addr_o = {half, bank[3:1], cpu A14}; bank register bit 0 has no effect.
- R7: cfg_flash_sz_i selects the fitted flash: 2'b00 = 128 KB (prg_addr_o bits 4:3 forced to 0), 2'b01 = 256 KB (bit 4 forced to 0), 2'b10 or 2'b11 = 512 KB (no masking).
- R8: rom_ce_n_o is low exactly when cpu A15 is 1; rom_oe_n_o is low only when A15 is 1 and cpu_rw_i is 1, so the flash never drives the bus during a write.
- R9: wram_ce_n_o is low only while m2_i is 1 and the address is in $6000-$7FFF; wram_page_o always equals page register bits 2:1.
- R10: cfg_mirror_i selects the nametable line: 2'b00 gives ciram_a10_o = ppu_a10_i, 2'b01 gives ppu_a11_i, 2'b10 or 2'b11 gives page register bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock, one edge per CPU bus cycle |
| rst_ni | input | 1 | Active-low reset |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU data bus |
| cpu_rw_i | input | 1 | CPU read (1) or write (0) |
| m2_i | input | 1 | CPU bus phase, high while the bus cycle is valid |
| ppu_a10_i | input | 1 | Video address bit 10 |
| ppu_a11_i | input | 1 | Video address bit 11 |
| cfg_prg32_i | input | 1 | Strap: 0 = 16 KB mode, 1 = 32 KB mode |
| cfg_flash_sz_i | input | 2 | Strap: fitted flash size |
| cfg_mirror_i | input | 2 | Strap: nametable arrangement |
| prg_addr_o | output | 5 | Flash address bits 18:14 |
| rom_ce_n_o | output | 1 | Flash chip enable, active low |
| rom_oe_n_o | output | 1 | Flash output enable, active low |
| wram_page_o | output | 2 | Work-RAM address bits 14:13 |
| wram_ce_n_o | output | 1 | Work-RAM chip enable, active low |
| ciram_a10_o | output | 1 | Nametable select to console video RAM |

## Verification
The assertions assume the straps are static between checks and that a CPU write is presented as cpu_rw_i low with m2_i high for exactly one clk_i edge, the bus holding its value until the following falling edge. The bench only changes inputs on the falling edge of clk_i, changes straps while no write is in flight, and probes write-side enables with m2_i low so that no unintended register load happens. Combinational outputs are assumed settled by the sampling edge, which the bench honours by comparing a fixed delay after each input change.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
    parameter int CPU_AW  = 16;
    parameter int REG_W   = 4;
    parameter int PRG_W   = 5;
    parameter int WPG_W   = 2;

    localparam logic [1:0] MIR_VERT = 2'b00;
    localparam logic [1:0] MIR_HORZ = 2'b01;

    typedef struct packed {
        logic [REG_W-1:0] page;
        logic [REG_W-1:0] bank;
    } map_regs_t;
endpackage

// File: rtl/map_regs.sv
module map_regs
    import cart_map_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [REG_W-1:0] data_i,
    output map_regs_t        regs_o
);
    map_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_lo_i) regs_d.page = data_i;
        if (wr_hi_i) regs_d.bank = data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign regs_o = regs_q;

    // R2
    page_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_lo_i |=> regs_q.page == $past(data_i));
    // R3
    bank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hi_i && !wr_lo_i) |=> (regs_q.bank == $past(data_i)) && $stable(regs_q.page));
endmodule

// File: rtl/map_prg_xlate.sv
module map_prg_xlate
    import cart_map_pkg::*;
(
    input  logic             half_i,
    input  logic [REG_W-1:0] bank_i,
    input  logic             a14_i,
    input  logic             mode32_i,
    input  logic [1:0]       size_i,
    output logic [PRG_W-1:0] prg_o
);
    localparam int ALWAYS_BITS = PRG_W - 2;
    logic [PRG_W-1:0] raw_d;
    logic [PRG_W-1:0] mask_d;

    always_comb begin
        if (mode32_i)  raw_d = {half_i, bank_i[REG_W-1:1], a14_i};
        else if (a14_i) raw_d = {half_i, {REG_W{1'b1}}};
        else           raw_d = {half_i, bank_i};
    end

    for (genvar i = 0; i < PRG_W; i++) begin : g_mask
        if (i < ALWAYS_BITS) begin : g_keep
            assign mask_d[i] = 1'b1;
        end else if (i == ALWAYS_BITS) begin : g_mid
            assign mask_d[i] = (size_i != 2'b00);
        end else begin : g_top
            assign mask_d[i] = size_i[1];
        end
    end

    assign prg_o = raw_d & mask_d;
endmodule

// File: rtl/map_wram_dec.sv
module map_wram_dec
    import cart_map_pkg::*;
(
    input  logic [2:0]       addr_hi_i,
    input  logic             m2_i,
    input  logic [WPG_W-1:0] sel_i,
    output logic             ce_n_o,
    output logic [WPG_W-1:0] page_o
);
    assign ce_n_o = !(m2_i && addr_hi_i == 3'b011);
    assign page_o = sel_i;
endmodule

// File: rtl/map_mirror.sv
module map_mirror
    import cart_map_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       a10_i,
    input  logic       a11_i,
    input  logic       single_i,
    output logic       ciram_o
);
    always_comb begin
        case (mode_i)
            MIR_VERT: ciram_o = a10_i;
            MIR_HORZ: ciram_o = a11_i;
            default:  ciram_o = single_i;
        endcase
    end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_map_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CPU_AW-1:0] cpu_addr_i,
    input  logic [7:0]        cpu_data_i,
    input  logic              cpu_rw_i,
    input  logic              m2_i,
    input  logic              ppu_a10_i,
    input  logic              ppu_a11_i,
    input  logic              cfg_prg32_i,
    input  logic [1:0]        cfg_flash_sz_i,
    input  logic [1:0]        cfg_mirror_i,
    output logic [PRG_W-1:0]  prg_addr_o,
    output logic              rom_ce_n_o,
    output logic              rom_oe_n_o,
    output logic [WPG_W-1:0]  wram_page_o,
    output logic              wram_ce_n_o,
    output logic              ciram_a10_o
);
    localparam int A15 = CPU_AW - 1;
    localparam int A14 = CPU_AW - 2;

    logic      cpu_wr, wr_lo, wr_hi;
    map_regs_t regs;
    logic      unused_bits;

    assign unused_bits = ^{cpu_data_i[7:REG_W], cpu_addr_i[A14-2:0]};

    assign cpu_wr = m2_i && !cpu_rw_i && cpu_addr_i[A15];
    assign wr_lo  = cpu_wr && !cpu_addr_i[A14];
    assign wr_hi  = cpu_wr &&  cpu_addr_i[A14];

    map_regs u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_lo_i(wr_lo),
        .wr_hi_i(wr_hi),
        .data_i (cpu_data_i[REG_W-1:0]),
        .regs_o (regs)
    );

    map_prg_xlate u_prg (
        .half_i  (regs.page[REG_W-1]),
        .bank_i  (regs.bank),
        .a14_i   (cpu_addr_i[A14]),
        .mode32_i(cfg_prg32_i),
        .size_i  (cfg_flash_sz_i),
        .prg_o   (prg_addr_o)
    );

    assign rom_ce_n_o = !cpu_addr_i[A15];
    assign rom_oe_n_o = !(cpu_addr_i[A15] && cpu_rw_i);

    map_wram_dec u_wram (
        .addr_hi_i(cpu_addr_i[A15:A14-1]),
        .m2_i     (m2_i),
        .sel_i    (regs.page[WPG_W:1]),
        .ce_n_o   (wram_ce_n_o),
        .page_o   (wram_page_o)
    );

    map_mirror u_mir (
        .mode_i  (cfg_mirror_i),
        .a10_i   (ppu_a10_i),
        .a11_i   (ppu_a11_i),
        .single_i(regs.page[0]),
        .ciram_o (ciram_a10_o)
    );

    // R5
    fixed_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_prg32_i && cpu_addr_i[A15:A14] == 2'b11) |-> prg_addr_o[2:0] == 3'b111);
    // R6
    half_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_prg32_i |-> prg_addr_o[0] == cpu_addr_i[A14]);
    // R7
    size_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_flash_sz_i == 2'b00) |-> prg_addr_o[PRG_W-1:PRG_W-2] == 2'b00);
    // R8
    rom_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpu_rw_i |-> rom_oe_n_o);
    // R9
    wram_m2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wram_ce_n_o |-> m2_i);
endmodule

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  data = 8'h00;
    logic        rw = 1'b1, m2 = 1'b0, a10 = 1'b0, a11 = 1'b0;
    logic        prg32 = 1'b0;
    logic [1:0]  fsz = 2'b10, mir = 2'b00;
    logic [4:0]  prg;
    logic        rce_n, roe_n, wce_n, ciram;
    logic [1:0]  wpg;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_mapper dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_data_i(data),
        .cpu_rw_i(rw), .m2_i(m2), .ppu_a10_i(a10), .ppu_a11_i(a11),
        .cfg_prg32_i(prg32), .cfg_flash_sz_i(fsz), .cfg_mirror_i(mir),
        .prg_addr_o(prg), .rom_ce_n_o(rce_n), .rom_oe_n_o(roe_n),
        .wram_page_o(wpg), .wram_ce_n_o(wce_n), .ciram_a10_o(ciram)
    );

    typedef struct {
        string      tag;
        logic [4:0] prg;
        logic       rce_n, roe_n, wce_n, ciram;
        logic [1:0] wpg;
    } exp_t;

    exp_t q[$];
    event sample_ev;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;
    logic [3:0] m_page = 4'h0, m_bank = 4'h0;

    function automatic logic [4:0] model_prg(input logic [15:0] ad);
        logic [4:0] raw, mask;
        if (prg32)       raw = {m_page[3], m_bank[3:1], ad[14]};
        else if (ad[14]) raw = {m_page[3], 4'hF};
        else             raw = {m_page[3], m_bank};
        mask = (fsz == 2'b00) ? 5'h07 : (fsz == 2'b01) ? 5'h0F : 5'h1F;
        return raw & mask;
    endfunction

    task automatic cpu_write(input logic [15:0] ad, input logic [7:0] dv);
        @(negedge clk);
        addr = ad; data = dv; rw = 1'b0; m2 = 1'b1;
        @(negedge clk);
        rw = 1'b1; m2 = 1'b0;
        if (ad[15] && !ad[14]) m_page = dv[3:0];
        if (ad[15] &&  ad[14]) m_bank = dv[3:0];
    endtask

    task automatic probe(input string tag, input logic [15:0] ad, input logic r,
                         input logic m, input logic p10, input logic p11);
        exp_t e;
        @(negedge clk);
        addr = ad; rw = r; m2 = m; a10 = p10; a11 = p11;
        e.tag   = tag;
        e.prg   = model_prg(ad);
        e.rce_n = !ad[15];
        e.roe_n = !(ad[15] && r);
        e.wce_n = !(m && ad[15:13] == 3'b011);
        e.wpg   = m_page[2:1];
        e.ciram = (mir == 2'b00) ? p10 : (mir == 2'b01) ? p11 : m_page[0];
        q.push_back(e);
        #1;
        -> sample_ev;
        #1;
    endtask

    // monitor: pops one expectation per sample event and compares all outputs
    initial begin
        exp_t e;
        forever begin
            @(sample_ev);
            e = q.pop_front();
            checks++;
            if (prg !== e.prg || rce_n !== e.rce_n || roe_n !== e.roe_n ||
                wce_n !== e.wce_n || wpg !== e.wpg || ciram !== e.ciram) begin
                errors++;
                $display("FAIL %s actual prg=%h rce_n=%b roe_n=%b wce_n=%b wpg=%h ciram=%b expected prg=%h rce_n=%b roe_n=%b wce_n=%b wpg=%h ciram=%b",
                         e.tag, prg, rce_n, roe_n, wce_n, wpg, ciram,
                         e.prg, e.rce_n, e.roe_n, e.wce_n, e.wpg, e.ciram);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        probe("R1 reset prg", 16'h8000, 1, 1, 0, 0);
        probe("R1 reset wram", 16'h6000, 1, 1, 0, 0);
        // R2, R4 page and bank loads in 16 KB mode
        cpu_write(16'h8000, 8'hFB);
        cpu_write(16'hC000, 8'h55);
        probe("R4 lower window", 16'h8123, 1, 1, 0, 0);
        probe("R5 fixed window", 16'hE000, 1, 1, 0, 0);
        probe("R2 wram page", 16'h7000, 1, 1, 0, 0);
        cpu_write(16'hBFFF, 8'h02);
        probe("R2 half clear", 16'h8000, 1, 1, 0, 0);
        probe("R5 fixed half0", 16'hFFFF, 1, 1, 0, 0);
        cpu_write(16'h8000, 8'h0B);
        // R3 bank write keeps page
        cpu_write(16'hC000, 8'h03);
        probe("R3 page kept", 16'h7FFF, 1, 1, 0, 0);
        probe("R3 bank loaded", 16'hA000, 1, 1, 0, 0);
        // R10 mirroring
        mir = 2'b00;
        probe("R10 vertical", 16'h0000, 1, 1, 1, 0);
        mir = 2'b01;
        probe("R10 horizontal", 16'h0000, 1, 1, 1, 0);
        probe("R10 horizontal a11", 16'h0000, 1, 1, 0, 1);
        mir = 2'b10;
        probe("R10 single", 16'h0000, 1, 1, 0, 0);
        mir = 2'b11;
        probe("R10 single alt", 16'h0000, 1, 1, 1, 1);
        // R7 flash size masks
        cpu_write(16'hC000, 8'h0D);
        fsz = 2'b01;
        probe("R7 256K", 16'h8000, 1, 1, 0, 0);
        fsz = 2'b00;
        probe("R7 128K", 16'h8000, 1, 1, 0, 0);
        probe("R7 128K fixed", 16'hC000, 1, 1, 0, 0);
        fsz = 2'b11;
        probe("R7 512K alt", 16'h8000, 1, 1, 0, 0);
        // R6 32 KB mode, bank bit 0 ignored
        prg32 = 1'b1;
        cpu_write(16'hC000, 8'h0B);
        probe("R6 low half", 16'h8000, 1, 1, 0, 0);
        probe("R6 high half", 16'hC000, 1, 1, 0, 0);
        cpu_write(16'hC000, 8'h0A);
        probe("R6 bit0 ignored", 16'hC000, 1, 1, 0, 0);
        probe("R6 bit0 ignored lo", 16'h9000, 1, 1, 0, 0);
        // R8 flash enables
        probe("R8 write no oe", 16'h9000, 0, 0, 0, 0);
        probe("R8 outside", 16'h4000, 1, 1, 0, 0);
        // R9 wram enable
        probe("R9 m2 low", 16'h6000, 1, 0, 0, 0);
        probe("R9 below window", 16'h5FFF, 1, 1, 0, 0);
        probe("R9 above window", 16'h8000, 1, 1, 0, 0);
        probe("R9 window write", 16'h6ABC, 0, 1, 0, 0);
        @(negedge clk);
        rw = 1'b1; m2 = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule